// File: doc/BRIEF.md
# Tunable Filter Calibration Sequencer

This block controls when a clock-referenced tunable filter runs its automatic calibration, when the filter is in manual fine-tune mode, and when its signal path is connected. It runs on the reference clock. A single control pin does two jobs. Holding it high selects manual mode, where a parallel bus supplies the fine-tune code. Lowering it after it has been high starts an automatic calibration. An external calibration engine answers with a done pulse and the code it found, or with a failure pulse that names the edge that did not settle.

The sequencer keeps the filter path isolated until a calibration has finished successfully. A window counter limits how long it waits for the engine. A chip-enable input sends the block into standby, which drops the tuned state but keeps the last calibrated code. Once the block is tuned it needs no further reference clock edges to stay tuned, so the clock may be stopped.

Top module: `filt_cal_seq`

## Requirements
- R1: After the control pin has been seen high and then low (through a two-flop synchronizer), `cal_start` pulses for exactly one cycle, and that cycle counts as window cycle 0. No pulse occurs without such a high-then-low sequence.
- R2: If `eng_done` is high in window cycle k with k < CAL_LIMIT (50), then on the next edge `tuned` goes to 1, `io_iso` goes to 0, and `tune_code` takes the `eng_code` value presented with the done pulse.
- R3: If no done pulse has arrived by window cycle CAL_LIMIT-1, the run ends with `err_lo`=1, `tuned`=0 and `io_iso`=1. A done pulse after that point is ignored. A new start clears both error flags.
- R4: An `eng_fail` pulse during the window ends the run. It sets `err_hi` when `eng_fail_hi`=1 and `err_lo` otherwise. `tuned` stays 0, at most one error flag is high, and neither is high while tuned.
- R5: While the synchronized control pin is high and the chip is enabled, `man_active`=1 and `tune_code` equals `man_code` in the same cycle. `io_iso` stays 1 in this mode.
- R6: With `chip_en` low, the next edge gives `tuned`=0, `io_iso`=1 and `man_active`=0. The last calibrated code is kept and appears again on `tune_code` after the chip is re-enabled, with the path still isolated.
- R7: After reset: `tuned`=0, `io_iso`=1, `err_lo`=`err_hi`=0, `cal_start`=0, `man_active`=0 and `tune_code`=0.
- R8: Raising the control pin during a run aborts it and returns to manual mode. A done pulse that arrives afterwards does not set `tuned`.
- R9: Once `tuned` is 1, it stays 1 and `io_iso` stays 0 while the reference clock is stopped.
- R10: A done pulse in the last window cycle (CAL_LIMIT-1) takes priority over the timeout and gives a successful run.
- R11: Activity on the control pin while in standby produces no `cal_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| chip_en | input | 1 | Chip enable; low selects standby |
| cal_pin | input | 1 | Asynchronous control pin: held high selects manual mode, high-then-low starts calibration |
| man_code | input | CODE_W | Parallel manual fine-tune code |
| eng_done | input | 1 | Calibration engine success pulse |
| eng_fail | input | 1 | Calibration engine settle-failure pulse |
| eng_fail_hi | input | 1 | Failing edge qualifier for eng_fail (1 = high edge) |
| eng_code | input | CODE_W | Code found by the engine, valid with eng_done |
| cal_start | output | 1 | One-cycle calibration start strobe |
| tuned | output | 1 | Calibration completed successfully |
| err_lo | output | 1 | Low-edge settle error |
| err_hi | output | 1 | High-edge settle error |
| io_iso | output | 1 | Filter input/output isolation request |
| man_active | output | 1 | Manual tune mode active |
| tune_code | output | CODE_W | Code driven to the filter core |

## Verification
Two events can fall in the same cycle: the engine's done pulse and the expiry of the window counter. The bench sweeps the done delay across every window cycle from 0 up to two cycles past the limit. At delay CAL_LIMIT-1 both events land on the same edge, and the run must end tuned with the engine's code. At delay CAL_LIMIT the run must already have ended with a low-edge error and must ignore the late pulse. The collision between a pin rise and a late done pulse is covered by the abort sequence, and the collision between standby and a running calibration is covered by dropping the enable in the middle of the window.

// File: rtl/filt_cal_pkg.sv
package filt_cal_pkg;

  typedef enum logic [2:0] {
    ST_STBY  = 3'd0,
    ST_IDLE  = 3'd1,
    ST_MAN   = 3'd2,
    ST_CAL   = 3'd3,
    ST_TUNED = 3'd4,
    ST_FAIL  = 3'd5
  } seq_state_t;

  // last admissible window cycle reached
  function automatic logic window_last(input int unsigned cnt, input int unsigned limit);
    return cnt == limit - 1;
  endfunction

endpackage

// File: rtl/filt_cal_sync.sv
module filt_cal_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_async,
  output logic pin_lvl,
  output logic pin_fall
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= pin_async;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign pin_lvl  = s2_q;
  assign pin_fall = s3_q & ~s2_q;

  AST_SYNC_FALL_FOLLOWS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    pin_fall |-> $past(pin_lvl)) else $error("fall without prior high"); // R1
endmodule

// File: rtl/filt_cal_timer.sv
module filt_cal_timer #(
  parameter int unsigned LIMIT = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  import filt_cal_pkg::*;
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  assign expired = run && window_last(32'(cnt_q), LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run)          cnt_q <= '0;
    else if (!expired)      cnt_q <= cnt_q + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(LIMIT)) else $error("window counter overran"); // R3
  AST_TIMER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt_q == '0) else $error("window counter not cleared"); // R3
endmodule

// File: rtl/filt_cal_fsm.sv
module filt_cal_fsm #(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              pin_lvl,
  input  logic              pin_fall,
  input  logic              expired,
  input  logic [CODE_W-1:0] man_code,
  input  logic              eng_done,
  input  logic              eng_fail,
  input  logic              eng_fail_hi,
  input  logic [CODE_W-1:0] eng_code,
  output logic              running,
  output logic              cal_start,
  output logic              tuned,
  output logic              err_lo,
  output logic              err_hi,
  output logic              io_iso,
  output logic              man_active,
  output logic [CODE_W-1:0] tune_code
);
  import filt_cal_pkg::*;

  seq_state_t        state_q;
  logic              start_q, tuned_q, iso_q, elo_q, ehi_q;
  logic [CODE_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_STBY;
      start_q <= 1'b0;
      tuned_q <= 1'b0;
      iso_q   <= 1'b1;
      elo_q   <= 1'b0;
      ehi_q   <= 1'b0;
      code_q  <= '0;
    end else begin
      start_q <= 1'b0;
      if (!chip_en) begin
        state_q <= ST_STBY;
        tuned_q <= 1'b0;
        iso_q   <= 1'b1;
        elo_q   <= 1'b0;
        ehi_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_STBY: state_q <= ST_IDLE;
          ST_IDLE, ST_TUNED, ST_FAIL, ST_CAL: begin
            if (pin_lvl) begin
              state_q <= ST_MAN;
              tuned_q <= 1'b0;
              iso_q   <= 1'b1;
              elo_q   <= 1'b0;
              ehi_q   <= 1'b0;
            end else if (state_q == ST_CAL) begin
              if (eng_done) begin
                state_q <= ST_TUNED;
                tuned_q <= 1'b1;
                iso_q   <= 1'b0;
                code_q  <= eng_code;
              end else if (eng_fail) begin
                state_q <= ST_FAIL;
                ehi_q   <= eng_fail_hi;
                elo_q   <= ~eng_fail_hi;
              end else if (expired) begin
                state_q <= ST_FAIL;
                elo_q   <= 1'b1;
              end
            end
          end
          ST_MAN: begin
            if (!pin_lvl) begin
              state_q <= ST_CAL;
              start_q <= 1'b1;
            end
          end
          default: state_q <= ST_STBY;
        endcase
      end
    end
  end

  assign running    = (state_q == ST_CAL);
  assign cal_start  = start_q;
  assign tuned      = tuned_q;
  assign io_iso     = iso_q;
  assign err_lo     = elo_q;
  assign err_hi     = ehi_q;
  assign man_active = (state_q == ST_MAN);
  assign tune_code  = man_active ? man_code : code_q;

  AST_START_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |-> $past(pin_fall)) else $error("start without falling pin"); // R1
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cal_start |=> !cal_start) else $error("start wider than one cycle"); // R1
  AST_TUNED_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tuned) |-> $past(eng_done)) else $error("tuned without done"); // R2
  AST_ISO_UNTIL_TUNED: assert property (@(posedge clk) disable iff (!rst_n)
    !tuned |-> io_iso) else $error("path released while untuned"); // R2
  AST_ERR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_lo, err_hi})) else $error("both error flags set"); // R4
  AST_TUNED_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    tuned |-> !(err_lo || err_hi)) else $error("error while tuned"); // R4
  AST_STBY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_en |=> (!tuned && io_iso && !man_active)) else $error("standby not entered"); // R6
endmodule

// File: rtl/filt_cal_seq.sv
module filt_cal_seq #(
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned CAL_LIMIT = 50
) (
  input  logic              clk_ref,
  input  logic              rst_n,
  input  logic              chip_en,
  input  logic              cal_pin,
  input  logic [CODE_W-1:0] man_code,
  input  logic              eng_done,
  input  logic              eng_fail,
  input  logic              eng_fail_hi,
  input  logic [CODE_W-1:0] eng_code,
  output logic              cal_start,
  output logic              tuned,
  output logic              err_lo,
  output logic              err_hi,
  output logic              io_iso,
  output logic              man_active,
  output logic [CODE_W-1:0] tune_code
);
  logic pin_lvl, pin_fall, running, expired;

  filt_cal_sync u_sync (
    .clk(clk_ref), .rst_n(rst_n), .pin_async(cal_pin),
    .pin_lvl(pin_lvl), .pin_fall(pin_fall)
  );

  filt_cal_timer #(.LIMIT(CAL_LIMIT)) u_timer (
    .clk(clk_ref), .rst_n(rst_n), .run(running), .expired(expired)
  );

  filt_cal_fsm #(.CODE_W(CODE_W)) u_fsm (
    .clk(clk_ref), .rst_n(rst_n), .chip_en(chip_en),
    .pin_lvl(pin_lvl), .pin_fall(pin_fall), .expired(expired),
    .man_code(man_code), .eng_done(eng_done), .eng_fail(eng_fail),
    .eng_fail_hi(eng_fail_hi), .eng_code(eng_code),
    .running(running), .cal_start(cal_start), .tuned(tuned),
    .err_lo(err_lo), .err_hi(err_hi), .io_iso(io_iso),
    .man_active(man_active), .tune_code(tune_code)
  );

  AST_EXPIRE_ONLY_RUNNING: assert property (@(posedge clk_ref) disable iff (!rst_n)
    expired |-> running) else $error("expiry outside window"); // R3
endmodule

// File: tb/filt_cal_seq_tb.sv
module filt_cal_seq_tb;
  localparam int CW  = 6;
  localparam int LIM = 50;

  logic clk_ref = 1'b0;
  logic clk_run = 1'b1;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, cal_pin = 1'b0;
  logic [CW-1:0] man_code = '0, eng_code = '0;
  logic eng_done = 1'b0, eng_fail = 1'b0, eng_fail_hi = 1'b0;
  logic cal_start, tuned, err_lo, err_hi, io_iso, man_active;
  logic [CW-1:0] tune_code;

  int vectors = 0, miscompares = 0;
  logic [CW-1:0] exp_code = '0;

  always begin #2; if (clk_run) clk_ref = ~clk_ref; end

  filt_cal_seq #(.CODE_W(CW), .CAL_LIMIT(LIM)) u_dut (
    .clk_ref(clk_ref), .rst_n(rst_n), .chip_en(chip_en), .cal_pin(cal_pin),
    .man_code(man_code), .eng_done(eng_done), .eng_fail(eng_fail),
    .eng_fail_hi(eng_fail_hi), .eng_code(eng_code), .cal_start(cal_start),
    .tuned(tuned), .err_lo(err_lo), .err_hi(err_hi), .io_iso(io_iso),
    .man_active(man_active), .tune_code(tune_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
  endtask

  // raise pin, hold, lower it, return once cal_start is seen (window cycle 0)
  task automatic launch(output bit seen);
    cal_pin = 1'b1;
    cyc(5);
    cal_pin = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < 8 && !seen; i++) begin
      @(negedge clk_ref);
      if (cal_start) seen = 1'b1;
    end
  endtask

  initial begin
    #600000;
    miscompares++;
    $display("FAIL watchdog expired during run (R1)");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    bit seen;
    int starts;
    cyc(3);
    // R7 reset state
    check("R7 tuned", tuned, 0);
    check("R7 io_iso", io_iso, 1);
    check("R7 errs", {err_lo, err_hi}, 0);
    check("R7 cal_start", cal_start, 0);
    check("R7 man_active", man_active, 0);
    check("R7 tune_code", tune_code, 0);
    rst_n = 1'b1;
    chip_en = 1'b1;
    cyc(4);
    check("R6 isolated before toggle", io_iso, 1);

    // R5 manual sweep of every code
    cal_pin = 1'b1;
    cyc(5);
    for (int v = 0; v < 64; v++) begin
      man_code = CW'(v);
      @(negedge clk_ref);
      check("R5 tune_code follows bus", tune_code, v);
      check("R5 man_active", man_active, 1);
      check("R5 io_iso in manual", io_iso, 1);
    end
    check("R1 no start while held", cal_start, 0);
    cal_pin = 1'b0;
    cyc(8);

    // R2/R3/R10 sweep of done delay across the window and past it
    for (int d = 0; d <= LIM + 2; d++) begin
      bit ok;
      eng_code = CW'((d * 5 + 3) % 64);
      launch(seen);
      check("R1 start strobe after toggle", seen, 1);
      for (int c = 0; c <= d; c++) begin
        eng_done = (c == d);
        @(negedge clk_ref);
      end
      eng_done = 1'b0;
      cyc(2);
      ok = (d < LIM);
      if (ok) exp_code = eng_code;
      check(d == LIM - 1 ? "R10 done on last cycle" : (ok ? "R2 tuned" : "R3 timeout tuned"), tuned, ok);
      check(ok ? "R2 io released" : "R3 io isolated", io_iso, !ok);
      check(ok ? "R2 no error" : "R3 err_lo", err_lo, !ok);
      check("R3 err_hi clear", err_hi, 0);
      check("R2 tune_code", tune_code, exp_code);
      check("R1 single strobe", cal_start, 0);
    end

    // R4 engine failure pulses, both edges
    for (int s = 0; s < 2; s++) begin
      launch(seen);
      cyc(3);
      eng_fail = 1'b1;
      eng_fail_hi = s[0];
      @(negedge clk_ref);
      eng_fail = 1'b0;
      cyc(2);
      check("R4 err_hi", err_hi, s);
      check("R4 err_lo", err_lo, 1 - s);
      check("R4 tuned low", tuned, 0);
      check("R4 io isolated", io_iso, 1);
    end

    // R8 abort by a new pin rise, late done ignored
    launch(seen);
    cyc(5);
    cal_pin = 1'b1;
    cyc(5);
    eng_done = 1'b1;
    eng_code = 6'h15;
    @(negedge clk_ref);
    eng_done = 1'b0;
    cyc(2);
    check("R8 tuned after abort", tuned, 0);
    check("R8 back in manual", man_active, 1);
    cal_pin = 1'b0;
    cyc(4);
    eng_code = 6'h2C;
    launch(seen);
    cyc(2);
    eng_done = 1'b1;
    @(negedge clk_ref);
    eng_done = 1'b0;
    exp_code = 6'h2C;
    cyc(2);
    check("R8 recal tuned", tuned, 1);
    check("R8 recal code", tune_code, exp_code);

    // R9 reference clock stopped while tuned
    clk_run = 1'b0;
    #500;
    check("R9 tuned holds", tuned, 1);
    check("R9 io stays released", io_iso, 0);
    clk_run = 1'b1;
    cyc(2);

    // R6/R11 standby: retention, pin activity ignored
    chip_en = 1'b0;
    @(negedge clk_ref);
    check("R6 tuned drops", tuned, 0);
    check("R6 io isolated", io_iso, 1);
    starts = 0;
    for (int i = 0; i < 24; i++) begin
      cal_pin = (i % 8) < 4;
      @(negedge clk_ref);
      if (cal_start) starts++;
      if (man_active) starts++;
    end
    cal_pin = 1'b0;
    cyc(4);
    check("R11 no start in standby", starts, 0);
    chip_en = 1'b1;
    cyc(4);
    check("R6 code retained", tune_code, exp_code);
    check("R6 isolated after enable", io_iso, 1);
    check("R6 untuned after enable", tuned, 0);

    // R6 standby during a run aborts it
    launch(seen);
    cyc(3);
    chip_en = 1'b0;
    @(negedge clk_ref);
    eng_done = 1'b1;
    @(negedge clk_ref);
    eng_done = 1'b0;
    chip_en = 1'b1;
    cyc(3);
    check("R6 run aborted by standby", tuned, 0);
    check("R6 io after abort", io_iso, 1);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule